// File: doc/BRIEF.md
# Clock-Gated 16-bit Pseudo-Random Bit Generator

This block produces a repeatable pseudo-random bit stream from a 16-stage shift register with external XOR feedback. Each step moves the register one place toward its output end; the stage farthest from the output takes the XOR of four tapped stages. The characteristic polynomial is x^16 + x^14 + x^13 + x^11 + 1, so any non-zero start value runs through all 65535 non-zero states before it repeats.

Each stage is clocked only in a cycle where its incoming value differs from its stored value. Without a step, no stage is clocked. The per-stage enables are brought out on `gate_en_o` so that the number of skipped clock edges can be counted. A parameter selects how this is built. One form is a plain enable flop. The other is a clock-gate cell whose enable is latched while the clock is low.

The output is a stream. `out_vld` is high whenever reset is released. A bit moves to the consumer in every cycle where both `out_vld` and `out_rdy` are high, and the next bit appears in the following cycle. When the consumer holds `out_rdy` low, that is back-pressure: `out_bit` and the whole state stay where they are for as long as it lasts. A seed is written with the plain strobe `seed_vld`. It takes priority over a step in the same cycle.

Top module: `prbg_gated16`

## Requirements
- R1: On a step, the new value of state bit 15 is the XOR of the old bits 0, 2, 3 and 5. Bit 0 is the output end. Bits 0, 2, 3 and 5 are stages 16, 14, 13 and 11 counted from bit 15.
- R2: On a step, each new bit i (for i from 0 to 14) takes the old bit i+1. `out_bit` always equals state bit 0.
- R3: When `out_rdy` is low and there is no seed load or reset, the state is unchanged after the clock and `gate_en_o` is all zeros.
- R4: Outside reset and seed load, `gate_en_o` bit i is high in a cycle exactly when state bit i changes at the next clock edge.
- R5: When `seed_vld` is high, the state takes `seed_data` at the next edge whatever `out_rdy` is, and `gate_en_o` is all ones in that cycle.
- R6: A seed load of all zeros puts the default value 0xACE1 into the state instead.
- R7: A synchronous reset puts 0xACE1 into the state. While reset is high, `out_vld` is low and `gate_en_o` is all ones.
- R8: Loading the same seed twice gives the same output bit sequence.
- R9: From a non-zero seed, with a step in every cycle, the state first returns to the seed after exactly 65535 steps.
- R10: In every cycle the state equals that of an ungated register with the same polynomial, fed the same inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| out_rdy | input | 1 | Consumer ready; with out_vld it steps the register |
| seed_vld | input | 1 | Seed load strobe |
| seed_data | input | 16 | Seed value (zero is replaced by the default) |
| out_vld | output | 1 | Output bit valid (high outside reset) |
| out_bit | output | 1 | Serial output bit, state bit 0 |
| state_o | output | 16 | Parallel register state |
| gate_en_o | output | 16 | Per-stage clock enable for this cycle |

## Verification
A seed load and a stream step can fall in the same cycle when `seed_vld` and `out_rdy` are both high. The random phase raises both together often, and directed cycles force the pair, including a zero seed. The result is judged by checking that the state equals the seed, or the default for a zero seed, and never the shifted value, and that `gate_en_o` shows all ones rather than the difference mask of a step.

// File: rtl/prbg_pkg.sv
package prbg_pkg;
  localparam int unsigned PRBG_W = 16;
  // Output end is bit 0; taps at bits 0,2,3,5 give x^16+x^14+x^13+x^11+1.
  localparam logic [PRBG_W-1:0] PRBG_TAPS = 16'h002D;
  localparam logic [PRBG_W-1:0] PRBG_DEFAULT = 16'hACE1;

  typedef enum logic [1:0] {
    ACT_IDLE = 2'd0,
    ACT_STEP = 2'd1,
    ACT_LOAD = 2'd2,
    ACT_RST  = 2'd3
  } prbg_act_e;
endpackage

// File: rtl/prbg_next.sv
module prbg_next #(
  parameter int unsigned W = 16,
  parameter logic [W-1:0] TAPS = 16'h002D
) (
  input  logic [W-1:0] cur,
  output logic [W-1:0] nxt
);
  logic [W-1:0] tapped;
  logic         fb;

  for (genvar i = 0; i < W; i++) begin : g_tap
    if (TAPS[i]) begin : g_on
      assign tapped[i] = cur[i];
    end else begin : g_off
      assign tapped[i] = 1'b0;
    end
  end

  assign fb  = ^tapped;
  assign nxt = {fb, cur[W-1:1]};
endmodule

// File: rtl/prbg_ctrl.sv
module prbg_ctrl
  import prbg_pkg::*;
#(
  parameter int unsigned W = 16,
  parameter logic [W-1:0] DEFAULT_SEED = 16'hACE1
) (
  input  logic         rst,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] seed,
  input  logic [W-1:0] cur,
  input  logic [W-1:0] nxt,
  output logic [W-1:0] d_vec,
  output logic [W-1:0] en_vec
);
  prbg_act_e act;
  logic [W-1:0] seed_fix;

  assign seed_fix = (seed == '0) ? DEFAULT_SEED : seed;

  always_comb begin
    if (rst)       act = ACT_RST;
    else if (load) act = ACT_LOAD;
    else if (step) act = ACT_STEP;
    else           act = ACT_IDLE;
  end

  always_comb begin
    unique case (act)
      ACT_RST: begin
        d_vec  = DEFAULT_SEED;
        en_vec = '1;
      end
      ACT_LOAD: begin
        d_vec  = seed_fix;
        en_vec = '1;
      end
      ACT_STEP: begin
        d_vec  = nxt;
        en_vec = nxt ^ cur;
      end
      default: begin
        d_vec  = cur;
        en_vec = '0;
      end
    endcase
  end
endmodule

// File: rtl/prbg_stage.sv
module prbg_stage #(
  parameter bit GATE_CELL = 1'b0
) (
  input  logic clk,
  input  logic en,
  input  logic d,
  output logic q
);
  if (GATE_CELL) begin : g_icg
    logic en_lat;
    logic gclk;
    // Enable passes only while clk is low, so gclk cannot glitch.
    always_latch begin
      if (!clk) en_lat = en;
    end
    assign gclk = clk & en_lat;
    always_ff @(posedge gclk) q <= d;
  end else begin : g_enff
    always_ff @(posedge clk) begin
      if (en) q <= d;
    end
  end
endmodule

// File: rtl/prbg_gated16.sv
module prbg_gated16 #(
  parameter int unsigned W = prbg_pkg::PRBG_W,
  parameter logic [W-1:0] TAPS = prbg_pkg::PRBG_TAPS,
  parameter logic [W-1:0] DEFAULT_SEED = prbg_pkg::PRBG_DEFAULT,
  parameter bit GATE_CELL = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         out_rdy,
  input  logic         seed_vld,
  input  logic [W-1:0] seed_data,
  output logic         out_vld,
  output logic         out_bit,
  output logic [W-1:0] state_o,
  output logic [W-1:0] gate_en_o
);
  logic [W-1:0] cur;
  logic [W-1:0] nxt;
  logic [W-1:0] d_vec;
  logic [W-1:0] en_vec;
  logic         step;

  assign out_vld = ~rst;
  assign step    = out_vld & out_rdy;

  prbg_next #(.W(W), .TAPS(TAPS)) u_next (
    .cur (cur),
    .nxt (nxt)
  );

  prbg_ctrl #(.W(W), .DEFAULT_SEED(DEFAULT_SEED)) u_ctrl (
    .rst    (rst),
    .load   (seed_vld),
    .step   (step),
    .seed   (seed_data),
    .cur    (cur),
    .nxt    (nxt),
    .d_vec  (d_vec),
    .en_vec (en_vec)
  );

  for (genvar i = 0; i < W; i++) begin : g_stage
    prbg_stage #(.GATE_CELL(GATE_CELL)) u_ff (
      .clk (clk),
      .en  (en_vec[i]),
      .d   (d_vec[i]),
      .q   (cur[i])
    );
  end

  assign state_o   = cur;
  assign out_bit   = cur[0];
  assign gate_en_o = en_vec;
endmodule

// File: rtl/prbg_gated16_chk.sv
module prbg_gated16_chk #(
  parameter int unsigned W = 16,
  parameter logic [W-1:0] TAPS = 16'h002D,
  parameter logic [W-1:0] DEFAULT_SEED = 16'hACE1
) (
  input logic         clk,
  input logic         rst,
  input logic         out_rdy,
  input logic         seed_vld,
  input logic [W-1:0] seed_data,
  input logic         out_vld,
  input logic         out_bit,
  input logic [W-1:0] state_o,
  input logic [W-1:0] gate_en_o
);
  // R1
  a_r1_feedback: assert property (@(posedge clk) disable iff (rst)
    (out_rdy && !seed_vld) |=> state_o[W-1] == ^($past(state_o) & TAPS));

  // R2
  a_r2_shift: assert property (@(posedge clk) disable iff (rst)
    (out_rdy && !seed_vld) |=> state_o[W-2:0] == $past(state_o[W-1:1]));

  // R3
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    (!out_rdy && !seed_vld) |=> $stable(state_o));

  // R4
  a_r4_activity: assert property (@(posedge clk) disable iff (rst)
    !seed_vld |=> (state_o ^ $past(state_o)) == $past(gate_en_o));

  // R5, R6
  a_r5_load: assert property (@(posedge clk) disable iff (rst)
    seed_vld |=> state_o == (($past(seed_data) == '0) ? DEFAULT_SEED : $past(seed_data)));

  // R7
  a_r7_reset: assert property (@(posedge clk)
    rst |=> (state_o == DEFAULT_SEED || rst == 1'b1) && state_o == DEFAULT_SEED);

  // R9: all-zero lock-up state never reached
  a_r9_nonzero: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> state_o != '0);
endmodule

bind prbg_gated16 prbg_gated16_chk #(
  .W(W), .TAPS(TAPS), .DEFAULT_SEED(DEFAULT_SEED)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .out_rdy   (out_rdy),
  .seed_vld  (seed_vld),
  .seed_data (seed_data),
  .out_vld   (out_vld),
  .out_bit   (out_bit),
  .state_o   (state_o),
  .gate_en_o (gate_en_o)
);

// File: tb/prbg_gated16_tb_top.sv
module prbg_gated16_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] DEF = 16'hACE1;

  logic        clk = 1'b0;
  logic        rst;
  logic        out_rdy;
  logic        seed_vld;
  logic [15:0] seed_data;
  logic        out_vld;
  logic        out_bit;
  logic [15:0] state_o;
  logic [15:0] gate_en_o;

  int total = 0;
  int bad = 0;
  logic [15:0] model;

  always #(CLK_PERIOD/2) clk = ~clk;

  prbg_gated16 dut_i (
    .clk(clk), .rst(rst), .out_rdy(out_rdy), .seed_vld(seed_vld),
    .seed_data(seed_data), .out_vld(out_vld), .out_bit(out_bit),
    .state_o(state_o), .gate_en_o(gate_en_o)
  );

  function automatic logic [15:0] ref_step(input logic [15:0] s);
    return {s[0] ^ s[2] ^ s[3] ^ s[5], s[15:1]};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called at a negative edge: drive, check the enables, clock, check state.
  task automatic cyc(input logic r, input logic rdy, input logic ld, input logic [15:0] sd);
    logic [15:0] exp_en;
    logic [15:0] exp_nx;
    rst = r; out_rdy = rdy; seed_vld = ld; seed_data = sd;
    #1;
    if (r) begin
      exp_en = 16'hFFFF; exp_nx = DEF;
    end else if (ld) begin
      exp_en = 16'hFFFF; exp_nx = (sd == 16'h0) ? DEF : sd;   // R5 R6
    end else if (rdy) begin
      exp_nx = ref_step(model); exp_en = exp_nx ^ model;     // R1 R2 R4
    end else begin
      exp_en = 16'h0; exp_nx = model;                         // R3
    end
    check(gate_en_o === exp_en, "R4 gate enables", {16'h0, gate_en_o}, {16'h0, exp_en});
    check(out_vld === ~r, "R7 out_vld", {31'h0, out_vld}, {31'h0, ~r});
    @(posedge clk);
    model = exp_nx;
    @(negedge clk);
    check(state_o === model, "R10 state vs ungated model", {16'h0, state_o}, {16'h0, model});
    check(out_bit === model[0], "R2 out_bit", {31'h0, out_bit}, {31'h0, model[0]});
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] rec [40];
    int n;
    void'($urandom(32'd2718));
    model = 16'h0;
    rst = 1'b1; out_rdy = 1'b0; seed_vld = 1'b0; seed_data = 16'h0;
    @(negedge clk);
    // R7: reset state
    cyc(1'b1, 1'b1, 1'b1, 16'h1234);
    check(state_o === DEF, "R7 reset value", {16'h0, state_o}, {16'h0, DEF});

    // R1/R2: directed single-bit patterns
    cyc(1'b0, 1'b0, 1'b1, 16'h0001);
    cyc(1'b0, 1'b1, 1'b0, 16'h0);
    check(state_o === 16'h8000, "R1 feedback from bit0", {16'h0, state_o}, 32'h8000);
    cyc(1'b0, 1'b0, 1'b1, 16'h0020);
    cyc(1'b0, 1'b1, 1'b0, 16'h0);
    check(state_o === 16'h8010, "R1 feedback from bit5", {16'h0, state_o}, 32'h8010);
    cyc(1'b0, 1'b0, 1'b1, 16'h0002);
    cyc(1'b0, 1'b1, 1'b0, 16'h0);
    check(state_o === 16'h0001, "R2 shift, untapped bit1", {16'h0, state_o}, 32'h0001);

    // R3: back-pressure holds state
    for (int i = 0; i < 5; i++) cyc(1'b0, 1'b0, 1'b0, 16'hFFFF);
    check(state_o === 16'h0001, "R3 hold under back-pressure", {16'h0, state_o}, 32'h0001);

    // R5/R6: load collides with step; zero seed
    cyc(1'b0, 1'b1, 1'b1, 16'h5A5A);
    check(state_o === 16'h5A5A, "R5 load beats step", {16'h0, state_o}, 32'h5A5A);
    cyc(1'b0, 1'b1, 1'b1, 16'h0000);
    check(state_o === DEF, "R6 zero seed replaced", {16'h0, state_o}, {16'h0, DEF});

    // R8: repeatability
    cyc(1'b0, 1'b0, 1'b1, 16'hBEEF);
    for (int i = 0; i < 40; i++) begin
      rec[i] = {15'h0, out_bit};
      cyc(1'b0, 1'b1, 1'b0, 16'h0);
    end
    for (int i = 0; i < 30; i++) cyc(1'b0, 1'($urandom), 1'b0, 16'h0);
    cyc(1'b0, 1'b0, 1'b1, 16'hBEEF);
    for (int i = 0; i < 40; i++) begin
      check(out_bit === rec[i][0], "R8 repeat sequence", {31'h0, out_bit}, {31'h0, rec[i][0]});
      cyc(1'b0, 1'b1, 1'b0, 16'h0);
    end

    // Random mix, including load+step collisions and mid-run reset
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] sd;
      sd = (($urandom % 8) == 0) ? 16'h0 : 16'($urandom);
      cyc(($urandom % 200) == 0, ($urandom % 4) != 0, ($urandom % 16) == 0, sd);
    end

    // R9: period from a fixed seed
    cyc(1'b0, 1'b0, 1'b1, 16'h1357);
    rst = 1'b0; seed_vld = 1'b0; out_rdy = 1'b1;
    n = 0;
    for (int i = 0; i < 70000; i++) begin
      @(negedge clk);
      n++;
      if (state_o === 16'h1357) break;
    end
    check(n == 65535, "R9 period", n, 65535);
    out_rdy = 1'b0;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule